// File: doc/BRIEF.md
# Prioritised Memory Select Decoder

This block sits between a small microcontroller's external bus and the memories of a companion device. From the bus address, the active-low read, write and program-fetch strobes, and a chip-enable input, it produces one select per memory element. The elements are eight paged primary-flash sectors, four secondary-flash sectors, one SRAM, one configuration-register window and a set of peripheral windows. All windows are parameters. The defaults place the primary flash across 0x0000-0x7FFF, banked by an 8-bit page register. The secondary sectors are 2 KiB each, starting at 0x6000. The SRAM covers 0x2000-0x3FFF. The configuration window is 256 bytes at 0x7F00, and the two peripheral windows are 256 bytes each at 0x7D00 and 0x7E00.

Windows may overlap across levels, and a fixed priority resolves the overlap. SRAM, configuration and peripheral windows form the top level. Secondary flash is the middle level and primary flash the lowest. A hit at a higher level blocks every lower level for that address. A mapping register decides whether each flash array, and the SRAM, answers program fetches, data reads or both. The page register and the mapping register sit inside the configuration window, where the bus can write them and read them back.

Top module: `mem_sel_decoder`

## Requirements
- R1: After reset the page register and the mapping register both read back as 0.
- R2: No select output is asserted unless `chip_en` is high and at least one of `rd_n`, `wr_n` or `psen_n` is low. A write attempted while `chip_en` is low leaves the registers unchanged.
- R3: An address inside the SRAM, configuration or peripheral window never asserts a secondary or primary select.
- R4: An address inside a secondary sector never asserts a primary select.
- R5: At most one select output is high at any time, and windows that share a level are checked at elaboration to be disjoint.
- R6: Inside the primary window, primary select `pri_sel[i]` is asserted only when the page register equals i. A page value of 8 or more selects no primary sector.
- R7: The mapping register controls which strobes each memory answers. Bit 0 lets the SRAM answer `psen_n`; the SRAM always answers `rd_n`. Bit 1 lets the secondary flash answer `rd_n` and bit 3 lets it answer `psen_n`. Bit 2 lets the primary flash answer `rd_n` and bit 4 lets it answer `psen_n`, so setting bits 2 and 4 puts the primary flash in combined space.
- R8: The configuration and peripheral selects answer `rd_n` and `wr_n` only, never a program fetch alone.
- R9: A write strobe selects the winning memory whatever the mapping bits are.
- R10: A write in the configuration window loads the page register at offset 0x10 and the low 5 bits of the mapping register at offset 0x20, on the next rising clock edge. A read in the window returns the page register at offset 0x10 and {3'b000, map} at offset 0x20 on `rdata`. Any other read returns 0.
- R11: Priority is decided on the address alone. If the winning window does not answer the present strobe, no lower-level select is asserted in its place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the page and mapping registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Device enable, active high |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| psen_n | input | 1 | Program fetch strobe, active low |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data for the configuration registers |
| rdata | output | 8 | Configuration register read data |
| pri_sel | output | 8 | Primary flash sector selects |
| sec_sel | output | 4 | Secondary flash sector selects |
| sram_sel | output | 1 | SRAM select |
| cfg_sel | output | 1 | Configuration window select |
| per_sel | output | 2 | Peripheral window selects |

## Verification
In one cycle the address can fall inside windows of two or three levels at once, and the present strobe may or may not be enabled for the window that wins. Directed cases place addresses at 0x2100 (SRAM over primary), 0x6100 and 0x7900 (secondary over primary) and 0x7D40/0x7F10 (top level over secondary). Each case is repeated with mapping values that enable or block the winner's strobe, so the bench can tell true suppression apart from a missing space bit. Random cycles draw addresses near every window, random strobe mixes and occasional register writes. A bench model recomputes the winner from ranges and the mapping bits, and every output is compared against it.

// File: rtl/msd_pkg.sv
package msd_pkg;
   localparam int DATA_W        = 8;
   localparam int MAP_W         = 5;
   localparam int CFG_SPAN_LOG2 = 8;
   localparam int MAP_SRAM_PS   = 0;
   localparam int MAP_SEC_RD    = 1;
   localparam int MAP_PRI_RD    = 2;
   localparam int MAP_SEC_PS    = 3;
   localparam int MAP_PRI_PS    = 4;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ps;
   } strobe_t;

   // address falls inside an aligned window of 2**span_log2 bytes
   function automatic logic in_window(input logic [31:0] a, input logic [31:0] base,
                                      input int span_log2);
      return (a >> span_log2) == (base >> span_log2);
   endfunction

   // two aligned windows share at least one address
   function automatic logic win_overlap(input logic [31:0] b0, input int l0,
                                        input logic [31:0] b1, input int l1);
      int m;
      m = (l0 > l1) ? l0 : l1;
      return (b0 >> m) == (b1 >> m);
   endfunction
endpackage

// File: rtl/msd_cfg_regs.sv
module msd_cfg_regs
   import msd_pkg::*;
#(
   parameter int         PAGE_W   = 8,
   parameter logic [7:0] PAGE_OFS = 8'h10,
   parameter logic [7:0] MAP_OFS  = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_sel,
   input  strobe_t           stb,
   input  logic [7:0]        offset,
   input  logic [DATA_W-1:0] wdata,
   output logic [PAGE_W-1:0] page_q,
   output logic [MAP_W-1:0]  map_q,
   output logic [DATA_W-1:0] rdata
);
   logic page_wr, map_wr;

   assign page_wr = win_sel && stb.wr && (offset == PAGE_OFS);
   assign map_wr  = win_sel && stb.wr && (offset == MAP_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         map_q  <= '0;
      end else begin
         if (page_wr) page_q <= wdata[PAGE_W-1:0];
         if (map_wr)  map_q  <= wdata[MAP_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (win_sel && stb.rd) begin
         if (offset == PAGE_OFS)     rdata = DATA_W'(page_q);
         else if (offset == MAP_OFS) rdata = DATA_W'(map_q);
      end
   end

   // R10: a page write is visible on the register output one edge later
   p_page_load_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      page_wr |=> page_q == $past(wdata[PAGE_W-1:0]));
   // R10: the mapping register holds its value between writes
   p_map_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !map_wr |=> $stable(map_q));
endmodule

// File: rtl/msd_window_match.sv
module msd_window_match
   import msd_pkg::*;
#(
   parameter int          ADDR_W         = 16,
   parameter int          PAGE_W         = 8,
   parameter int          PRI_SECTORS    = 8,
   parameter logic [31:0] PRI_BASE       = 32'h0000,
   parameter int          PRI_SPAN_LOG2  = 15,
   parameter int          SEC_SECTORS    = 4,
   parameter logic [31:0] SEC_BASE       = 32'h6000,
   parameter int          SEC_SPAN_LOG2  = 11,
   parameter logic [31:0] SRAM_BASE      = 32'h2000,
   parameter int          SRAM_SPAN_LOG2 = 13,
   parameter logic [31:0] CFG_BASE       = 32'h7F00,
   parameter int          PER_COUNT      = 2,
   parameter logic [31:0] PER_BASE       = 32'h7D00,
   parameter int          PER_SPAN_LOG2  = 8
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic [PAGE_W-1:0]      page_q,
   output logic [PRI_SECTORS-1:0] pri_hit,
   output logic [SEC_SECTORS-1:0] sec_hit,
   output logic                   sram_hit,
   output logic                   cfg_hit,
   output logic [PER_COUNT-1:0]   per_hit
);
   logic [31:0] addr_x;
   logic        pri_win;

   assign addr_x   = 32'(addr);
   assign pri_win  = in_window(addr_x, PRI_BASE, PRI_SPAN_LOG2);
   assign sram_hit = in_window(addr_x, SRAM_BASE, SRAM_SPAN_LOG2);
   assign cfg_hit  = in_window(addr_x, CFG_BASE, CFG_SPAN_LOG2);

   for (genvar i = 0; i < PRI_SECTORS; i++) begin : g_pri
      assign pri_hit[i] = pri_win && (page_q == PAGE_W'(i));
   end

   for (genvar j = 0; j < SEC_SECTORS; j++) begin : g_sec
      localparam logic [31:0] SB = SEC_BASE + (32'(j) << SEC_SPAN_LOG2);
      assign sec_hit[j] = in_window(addr_x, SB, SEC_SPAN_LOG2);
   end

   for (genvar k = 0; k < PER_COUNT; k++) begin : g_per
      localparam logic [31:0] PB = PER_BASE + (32'(k) << PER_SPAN_LOG2);
      assign per_hit[k] = in_window(addr_x, PB, PER_SPAN_LOG2);
   end

   // R5: elaboration checks on parameters and same-level disjointness
   initial begin
      a_page_span_r5 : assert (PRI_SECTORS >= 1 && PRI_SECTORS <= (1 << PAGE_W))
         else $error("primary sector count does not fit the page register");
      a_addr_span_r5 : assert (PRI_SPAN_LOG2 <= ADDR_W && SRAM_SPAN_LOG2 <= ADDR_W)
         else $error("window wider than the address bus");
      a_cfg_sram_r5 : assert (!win_overlap(CFG_BASE, CFG_SPAN_LOG2, SRAM_BASE, SRAM_SPAN_LOG2))
         else $error("configuration window overlaps SRAM");
      for (int k = 0; k < PER_COUNT; k++) begin
         a_per_top_r5 : assert (
            !win_overlap(PER_BASE + (32'(k) << PER_SPAN_LOG2), PER_SPAN_LOG2,
                         CFG_BASE, CFG_SPAN_LOG2) &&
            !win_overlap(PER_BASE + (32'(k) << PER_SPAN_LOG2), PER_SPAN_LOG2,
                         SRAM_BASE, SRAM_SPAN_LOG2))
            else $error("peripheral window overlaps another top-level window");
      end
   end
endmodule

// File: rtl/msd_priority.sv
module msd_priority
   import msd_pkg::*;
#(
   parameter int PRI_SECTORS = 8,
   parameter int SEC_SECTORS = 4,
   parameter int PER_COUNT   = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   chip_en,
   input  strobe_t                stb,
   input  logic [MAP_W-1:0]       map_q,
   input  logic [PRI_SECTORS-1:0] pri_hit,
   input  logic [SEC_SECTORS-1:0] sec_hit,
   input  logic                   sram_hit,
   input  logic                   cfg_hit,
   input  logic [PER_COUNT-1:0]   per_hit,
   output logic [PRI_SECTORS-1:0] pri_sel,
   output logic [SEC_SECTORS-1:0] sec_sel,
   output logic                   sram_sel,
   output logic                   cfg_sel,
   output logic [PER_COUNT-1:0]   per_sel
);
   logic act, top_hit, mid_hit;
   logic sram_ok, sec_ok, pri_ok, io_ok;

   assign act     = chip_en && (stb.rd || stb.wr || stb.ps);
   assign top_hit = sram_hit || cfg_hit || (|per_hit);
   assign mid_hit = |sec_hit;

   assign io_ok   = stb.wr || stb.rd;
   assign sram_ok = io_ok || (stb.ps && map_q[MAP_SRAM_PS]);
   assign sec_ok  = stb.wr || (stb.rd && map_q[MAP_SEC_RD]) || (stb.ps && map_q[MAP_SEC_PS]);
   assign pri_ok  = stb.wr || (stb.rd && map_q[MAP_PRI_RD]) || (stb.ps && map_q[MAP_PRI_PS]);

   assign sram_sel = act && sram_hit && sram_ok;
   assign cfg_sel  = act && cfg_hit && io_ok;
   assign per_sel  = per_hit & {PER_COUNT{act && io_ok}};
   assign sec_sel  = sec_hit & {SEC_SECTORS{act && !top_hit && sec_ok}};
   assign pri_sel  = pri_hit & {PRI_SECTORS{act && !top_hit && !mid_hit && pri_ok}};

   p_one_winner_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pri_sel, sec_sel, sram_sel, cfg_sel, per_sel}));
   p_idle_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en || !(stb.rd || stb.wr || stb.ps)) |->
         ({pri_sel, sec_sel, sram_sel, cfg_sel, per_sel} == '0));
   p_top_blocks_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      top_hit |-> (sec_sel == '0) && (pri_sel == '0));
   p_mid_blocks_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      mid_hit |-> (pri_sel == '0));
   p_fetch_no_io_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb.ps && !stb.rd && !stb.wr) |-> !cfg_sel && (per_sel == '0));
endmodule

// File: rtl/mem_sel_decoder.sv
module mem_sel_decoder
   import msd_pkg::*;
#(
   parameter int          ADDR_W         = 16,
   parameter int          PAGE_W         = 8,
   parameter int          PRI_SECTORS    = 8,
   parameter logic [31:0] PRI_BASE       = 32'h0000,
   parameter int          PRI_SPAN_LOG2  = 15,
   parameter int          SEC_SECTORS    = 4,
   parameter logic [31:0] SEC_BASE       = 32'h6000,
   parameter int          SEC_SPAN_LOG2  = 11,
   parameter logic [31:0] SRAM_BASE      = 32'h2000,
   parameter int          SRAM_SPAN_LOG2 = 13,
   parameter logic [31:0] CFG_BASE       = 32'h7F00,
   parameter int          PER_COUNT      = 2,
   parameter logic [31:0] PER_BASE       = 32'h7D00,
   parameter int          PER_SPAN_LOG2  = 8,
   parameter logic [7:0]  PAGE_OFS       = 8'h10,
   parameter logic [7:0]  MAP_OFS        = 8'h20
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   chip_en,
   input  logic                   rd_n,
   input  logic                   wr_n,
   input  logic                   psen_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [7:0]             wdata,
   output logic [7:0]             rdata,
   output logic [PRI_SECTORS-1:0] pri_sel,
   output logic [SEC_SECTORS-1:0] sec_sel,
   output logic                   sram_sel,
   output logic                   cfg_sel,
   output logic [PER_COUNT-1:0]   per_sel
);
   strobe_t                stb;
   logic [PAGE_W-1:0]      page_q;
   logic [MAP_W-1:0]       map_q;
   logic [PRI_SECTORS-1:0] pri_hit;
   logic [SEC_SECTORS-1:0] sec_hit;
   logic                   sram_hit, cfg_hit;
   logic [PER_COUNT-1:0]   per_hit;

   assign stb.rd = !rd_n;
   assign stb.wr = !wr_n;
   assign stb.ps = !psen_n;

   msd_window_match #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
      .PRI_SECTORS(PRI_SECTORS), .PRI_BASE(PRI_BASE), .PRI_SPAN_LOG2(PRI_SPAN_LOG2),
      .SEC_SECTORS(SEC_SECTORS), .SEC_BASE(SEC_BASE), .SEC_SPAN_LOG2(SEC_SPAN_LOG2),
      .SRAM_BASE(SRAM_BASE), .SRAM_SPAN_LOG2(SRAM_SPAN_LOG2), .CFG_BASE(CFG_BASE),
      .PER_COUNT(PER_COUNT), .PER_BASE(PER_BASE), .PER_SPAN_LOG2(PER_SPAN_LOG2)
   ) u_match (
      .addr(addr), .page_q(page_q), .pri_hit(pri_hit), .sec_hit(sec_hit),
      .sram_hit(sram_hit), .cfg_hit(cfg_hit), .per_hit(per_hit)
   );

   msd_priority #(
      .PRI_SECTORS(PRI_SECTORS), .SEC_SECTORS(SEC_SECTORS), .PER_COUNT(PER_COUNT)
   ) u_prio (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .stb(stb), .map_q(map_q),
      .pri_hit(pri_hit), .sec_hit(sec_hit), .sram_hit(sram_hit), .cfg_hit(cfg_hit),
      .per_hit(per_hit), .pri_sel(pri_sel), .sec_sel(sec_sel), .sram_sel(sram_sel),
      .cfg_sel(cfg_sel), .per_sel(per_sel)
   );

   msd_cfg_regs #(
      .PAGE_W(PAGE_W), .PAGE_OFS(PAGE_OFS), .MAP_OFS(MAP_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .win_sel(cfg_sel), .stb(stb), .offset(addr[7:0]),
      .wdata(wdata), .page_q(page_q), .map_q(map_q), .rdata(rdata)
   );
endmodule

// File: tb/tb_mem_sel_decoder.sv
module tb_mem_sel_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chip_en = 1'b0, rd_n = 1'b1, wr_n = 1'b1, psen_n = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [7:0]  pri_sel;
   logic [3:0]  sec_sel;
   logic        sram_sel, cfg_sel;
   logic [1:0]  per_sel;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] m_page = '0;
   logic [4:0] m_map  = '0;

   always #10 clk = ~clk;

   mem_sel_decoder dut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .rd_n(rd_n), .wr_n(wr_n),
      .psen_n(psen_n), .addr(addr), .wdata(wdata), .rdata(rdata), .pri_sel(pri_sel),
      .sec_sel(sec_sel), .sram_sel(sram_sel), .cfg_sel(cfg_sel), .per_sel(per_sel)
   );

   // expected {pri[7:0], sec[3:0], sram, cfg, per[1:0]}
   function automatic logic [15:0] exp_sel(input logic ce, input logic r, input logic w,
                                           input logic p, input logic [15:0] a);
      logic [7:0] pri; logic [3:0] sec; logic sr, cf; logic [1:0] pe;
      logic go, top, mid;
      pri = '0; sec = '0; sr = 0; cf = 0; pe = '0;
      go  = ce && (r || w || p);
      top = (a >= 16'h2000 && a < 16'h4000) || (a[15:8] == 8'h7F) ||
            (a[15:8] == 8'h7D) || (a[15:8] == 8'h7E);
      mid = (a >= 16'h6000 && a < 16'h8000);
      if (go) begin
         if (a >= 16'h2000 && a < 16'h4000) sr = r || w || (p && m_map[0]);
         if (a[15:8] == 8'h7F) cf = r || w;
         if (a[15:8] == 8'h7D) pe[0] = r || w;
         if (a[15:8] == 8'h7E) pe[1] = r || w;
         if (!top && mid && (w || (r && m_map[1]) || (p && m_map[3])))
            sec[(a - 16'h6000) >> 11] = 1'b1;
         if (!top && !mid && a < 16'h8000 && m_page < 8 &&
             (w || (r && m_map[2]) || (p && m_map[4])))
            pri[m_page[2:0]] = 1'b1;
      end
      return {pri, sec, sr, cf, pe};
   endfunction

   function automatic logic [7:0] exp_rd(input logic ce, input logic r, input logic [15:0] a);
      if (ce && r && a[15:8] == 8'h7F) begin
         if (a[7:0] == 8'h10) return m_page;
         if (a[7:0] == 8'h20) return {3'b000, m_map};
      end
      return 8'h00;
   endfunction

   // one bus cycle: drive at falling edge, check, then commit at rising edge
   task automatic cyc(input string tag, input logic ce, input logic r, input logic w,
                      input logic p, input logic [15:0] a, input logic [7:0] d);
      logic [15:0] es, got;
      logic [7:0]  er;
      @(negedge clk);
      chip_en = ce; rd_n = !r; wr_n = !w; psen_n = !p; addr = a; wdata = d;
      #2;
      es  = exp_sel(ce, r, w, p, a);
      er  = exp_rd(ce, r, a);
      got = {pri_sel, sec_sel, sram_sel, cfg_sel, per_sel};
      n_tests++;
      if (got !== es || rdata !== er) begin
         n_fail++;
         $display("FAIL %s addr=%h sel=%h exp=%h rdata=%h exp=%h", tag, a, got, es, rdata, er);
      end
      @(posedge clk);
      if (ce && w && a[15:8] == 8'h7F) begin
         if (a[7:0] == 8'h10) m_page = d;
         if (a[7:0] == 8'h20) m_map  = d[4:0];
      end
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1 reset values
      cyc("R1 page", 1, 1, 0, 0, 16'h7F10, 8'h00);
      cyc("R1 map",  1, 1, 0, 0, 16'h7F20, 8'h00);
      // R2 no enable or no strobe
      cyc("R2 ce low", 0, 1, 0, 0, 16'h2100, 8'h00);
      cyc("R2 no strobe", 1, 0, 0, 0, 16'h2100, 8'h00);
      // R7 primary absent from both spaces at reset
      cyc("R7 pri rd off", 1, 1, 0, 0, 16'h0100, 8'h00);
      cyc("R7 pri ps off", 1, 0, 0, 1, 16'h0100, 8'h00);
      cyc("R10 map write", 1, 0, 1, 0, 16'h7F20, 8'h14);
      cyc("R7 pri rd combined", 1, 1, 0, 0, 16'h0100, 8'h00);
      cyc("R7 pri ps combined", 1, 0, 0, 1, 16'h0100, 8'h00);
      // R6 paging
      cyc("R10 page write", 1, 0, 1, 0, 16'h7F10, 8'h05);
      cyc("R6 sector 5", 1, 1, 0, 0, 16'h0100, 8'h00);
      cyc("R10 page readback", 1, 1, 0, 0, 16'h7F10, 8'h00);
      cyc("R10 other offset", 1, 1, 0, 0, 16'h7F33, 8'h00);
      cyc("R2 blocked write", 0, 0, 1, 0, 16'h7F10, 8'h77);
      cyc("R2 page unchanged", 1, 1, 0, 0, 16'h7F10, 8'h00);
      cyc("R10 page write", 1, 0, 1, 0, 16'h7F10, 8'h09);
      cyc("R6 page out of range", 1, 1, 0, 0, 16'h0100, 8'h00);
      cyc("R10 page write", 1, 0, 1, 0, 16'h7F10, 8'h03);
      // R3 and R11 SRAM over primary
      cyc("R3 sram rd", 1, 1, 0, 0, 16'h2100, 8'h00);
      cyc("R11 sram ps blocked", 1, 0, 0, 1, 16'h2100, 8'h00);
      // R4 and R11 secondary over primary
      cyc("R11 sec rd blocked", 1, 1, 0, 0, 16'h6100, 8'h00);
      cyc("R10 map write", 1, 0, 1, 0, 16'h7F20, 8'h1F);
      cyc("R4 sec 0", 1, 1, 0, 0, 16'h6100, 8'h00);
      cyc("R4 sec 3", 1, 0, 0, 1, 16'h7900, 8'h00);
      cyc("R7 sram ps", 1, 0, 0, 1, 16'h2100, 8'h00);
      cyc("R3 per 0", 1, 1, 0, 0, 16'h7D40, 8'h00);
      cyc("R3 per 1", 1, 0, 1, 0, 16'h7E40, 8'h00);
      cyc("R8 cfg fetch", 1, 0, 0, 1, 16'h7F10, 8'h00);
      cyc("R8 per fetch", 1, 0, 0, 1, 16'h7D00, 8'h00);
      cyc("R10 map write", 1, 0, 1, 0, 16'h7F20, 8'h00);
      cyc("R9 sec write", 1, 0, 1, 0, 16'h6900, 8'h00);
      cyc("R9 pri write", 1, 0, 1, 0, 16'h0100, 8'h00);
      cyc("R10 map readback", 1, 1, 0, 0, 16'h7F20, 8'h00);
      // R5 random mix
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] a;
         logic [2:0]  s;
         logic [7:0]  d;
         case ($urandom % 8)
            0: a = 16'h7F00 | (($urandom % 2) ? 16'h0010 : 16'h0020);
            1: a = 16'h2000 + 16'($urandom % 16'h2000);
            2: a = 16'h6000 + 16'($urandom % 16'h2000);
            3: a = 16'h7D00 + 16'($urandom % 16'h0300);
            4: a = 16'($urandom % 16'h8000);
            default: a = 16'($urandom);
         endcase
         s = 3'($urandom);
         d = ($urandom % 4 == 0) ? 8'($urandom % 12) : 8'($urandom);
         cyc("R5 random", ($urandom % 8) != 0, s[0], s[1], s[2], a, d);
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule